// File: doc/BRIEF.md
# Half-Warp Memory Access Coalescer

The block receives the memory request of one 32-thread warp: one address per thread, a mask of active threads and a single access-size code shared by the warp. It splits the warp into a lower half-warp (threads 0 to 15) and an upper half-warp (threads 16 to 31). It serves the lower half completely before the upper half. For each half it decides whether the accesses can be merged into wide aligned transactions. If they cannot, it issues one narrow transaction per active thread.

Transactions leave the block on a valid/ready stream. Each transaction is a base byte address plus a byte length. The request side is a valid/ready pair as well. A warp is taken only when the block is idle, which means every transaction of the previous warp has been consumed.

Top module: `hw_coalescer`

## Requirements
- R1: After reset, `txn_valid` is 0 and `req_ready` is 1.
- R2: `req_ready` is 1 only when no warp is in progress. While any transaction of the current warp is still pending, it stays 0. When the lower half of the accepted warp has an active thread, `txn_valid` is 1 in the first cycle after the accepting clock edge.
- R3: For size code 0 (4-byte words), a half that meets the merge rule is served by exactly one transaction. Its address is the segment base and its length is 64.
- R4: For size code 1 (8-byte words), a half that meets the merge rule is served by exactly one transaction. Its address is the segment base and its length is 128.
- R5: For size code 2 (16-byte words), a half that meets the merge rule is served by exactly two transactions of length 128. The first has address base and the second has address base+128.
- R6: Merge rule. Let W be the word size. Every active thread k of the half (k = 0..15, relative to the half) must address base + k·W. The base is one common value for the half. It must be a multiple of 64 for code 0 and a multiple of 128 for codes 1 and 2. Inactive threads impose no constraint.
- R7: When the merge rule fails, the half is served by one transaction per active thread, in ascending thread order. Each transaction carries that thread's own address and a length of W = 4·2^code bytes. Inactive threads produce nothing.
- R8: Size code 3 never merges. It always takes the per-thread path with a length of 32 bytes.
- R9: Every transaction of the lower half is issued before any transaction of the upper half.
- R10: A half with no active thread issues no transaction. A warp with an all-zero mask produces no transaction, and `req_ready` returns to 1 within 3 cycles of acceptance.
- R11: While `txn_valid` is 1 and `txn_ready` is 0, the next cycle keeps `txn_valid` at 1 and keeps `txn_addr` and `txn_len` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Warp request present |
| req_ready | output | 1 | Block idle, can take a warp |
| req_addr | input | WARP*ADDR_W | Per-thread byte addresses; thread k at bits [k*ADDR_W +: ADDR_W] |
| req_mask | input | WARP | Per-thread active bits |
| req_size | input | 2 | Access-size code: 0=4 B, 1=8 B, 2=16 B, 3=reserved |
| txn_valid | output | 1 | Transaction descriptor present |
| txn_ready | input | 1 | Consumer takes the descriptor |
| txn_addr | output | ADDR_W | Transaction byte address |
| txn_len | output | LEN_W | Transaction length in bytes |

## Verification
A warp is accepted on the clock edge where `req_valid` and `req_ready` are both high. The first descriptor of a non-empty lower half then appears in the cycle immediately after that edge. Each later descriptor follows in the cycle after its predecessor's handshake edge. Each empty half costs exactly one cycle with `txn_valid` low. The bench drives inputs and samples outputs on falling edges, so each cycle's values are read half a period after the edge that produced them. It records a descriptor only when valid and ready are both seen high at a falling edge. It compares the recorded list, in order, against a list built from the rules. A stall pattern on `txn_ready` checks that every held descriptor is unchanged one cycle later.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
    typedef enum logic [1:0] {
        SZ_W4   = 2'd0,
        SZ_W8   = 2'd1,
        SZ_W16  = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } state_e;

    // Word size in bytes for a size code: 4, 8, 16, and 32 for the reserved code.
    function automatic logic [7:0] word_bytes(input logic [1:0] code);
        return 8'd4 << code;
    endfunction

    // Length of one merged transaction.
    function automatic logic [7:0] wide_bytes(input logic [1:0] code);
        return (code == SZ_W4) ? 8'd64 : 8'd128;
    endfunction
endpackage

// File: rtl/hwc_first_set.sv
module hwc_first_set #(
    parameter int N = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          found
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

    // The reported index must point at a set bit: R7 picks the thread it names.
    always_comb begin
        if (!$isunknown(vec) && found) begin
            a_pick_set_r7: assert (vec[idx])
                else $error("first_set picked a clear bit");
        end
    end
endmodule

// File: rtl/hwc_half_rule.sv
module hwc_half_rule #(
    parameter int ADDR_W = 32,
    parameter int HALF   = 16,
    localparam int HIW = $clog2(HALF)
) (
    input  logic [HALF*ADDR_W-1:0] addrs,
    input  logic [HALF-1:0]        mask,
    input  logic [1:0]             size,
    output logic                   ok,
    output logic [ADDR_W-1:0]      base
);
    import hwc_pkg::*;

    logic [ADDR_W-1:0] cand [HALF];
    logic [HALF-1:0]   match;
    logic [HIW-1:0]    lead;
    logic              any;
    logic [2:0]        shamt;
    logic [ADDR_W-1:0] align_mask;

    assign shamt = {1'b0, size} + 3'd2;

    hwc_first_set #(.N(HALF)) u_lead (
        .vec   (mask),
        .idx   (lead),
        .found (any)
    );

    assign base = cand[lead];

    generate
        for (genvar k = 0; k < HALF; k++) begin : g_thr
            // Segment base implied by thread k if it sits on word k.
            assign cand[k]  = addrs[k*ADDR_W +: ADDR_W] - (ADDR_W'(k) << shamt);
            assign match[k] = !mask[k] || (cand[k] == base);
        end
    endgenerate

    assign align_mask = ADDR_W'(wide_bytes(size)) - ADDR_W'(1);
    assign ok = any && (size != SZ_RSVD) && (&match) && ((base & align_mask) == '0);
endmodule

// File: rtl/hw_coalescer.sv
module hw_coalescer #(
    parameter int ADDR_W = 32,
    parameter int WARP   = 32,
    parameter int LEN_W  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [WARP*ADDR_W-1:0] req_addr,
    input  logic [WARP-1:0]        req_mask,
    input  logic [1:0]             req_size,
    output logic                   txn_valid,
    input  logic                   txn_ready,
    output logic [ADDR_W-1:0]      txn_addr,
    output logic [LEN_W-1:0]       txn_len
);
    import hwc_pkg::*;

    localparam int HALF = WARP / 2;
    localparam int HIW  = $clog2(HALF);

    typedef struct packed {
        state_e                 st;
        logic                   half;
        logic                   wsub;
        logic [HALF-1:0]        pend;
        logic [WARP-1:0]        mask;
        logic [1:0]             size;
        logic [WARP*ADDR_W-1:0] addr;
    } ctl_t;

    ctl_t q, d;

    logic [HALF*ADDR_W-1:0] cur_addrs;
    logic [HALF-1:0]        cur_mask;
    logic                   coal;
    logic [ADDR_W-1:0]      seg_base;
    logic [HIW-1:0]         pidx;
    logic                   pfound;
    logic                   busy_half;
    logic                   advance;

    assign cur_addrs = q.addr[(q.half ? HALF*ADDR_W : 0) +: HALF*ADDR_W];
    assign cur_mask  = q.mask[(q.half ? HALF : 0) +: HALF];
    assign busy_half = (q.st == ST_ISSUE) && (cur_mask != '0);

    hwc_half_rule #(.ADDR_W(ADDR_W), .HALF(HALF)) u_rule (
        .addrs (cur_addrs),
        .mask  (cur_mask),
        .size  (q.size),
        .ok    (coal),
        .base  (seg_base)
    );

    hwc_first_set #(.N(HALF)) u_pick (
        .vec   (q.pend),
        .idx   (pidx),
        .found (pfound)
    );

    always_comb begin
        d       = q;
        advance = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st   = ST_ISSUE;
                    d.half = 1'b0;
                    d.wsub = 1'b0;
                    d.mask = req_mask;
                    d.size = req_size;
                    d.addr = req_addr;
                    d.pend = req_mask[HALF-1:0];
                end
            end
            default: begin
                if (cur_mask == '0) begin
                    advance = 1'b1;
                end else if (coal) begin
                    if (txn_ready) begin
                        if (q.size == SZ_W16 && !q.wsub) d.wsub = 1'b1;
                        else                             advance = 1'b1;
                    end
                end else if (txn_ready) begin
                    d.pend[pidx] = 1'b0;
                    if (d.pend == '0) advance = 1'b1;
                end
                if (advance) begin
                    d.wsub = 1'b0;
                    if (!q.half) begin
                        d.half = 1'b1;
                        d.pend = q.mask[WARP-1:HALF];
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign txn_valid = busy_half && (coal || pfound);
    assign txn_addr  = coal ? (seg_base + (q.wsub ? ADDR_W'(128) : ADDR_W'(0)))
                            : cur_addrs[pidx*ADDR_W +: ADDR_W];
    assign txn_len   = coal ? LEN_W'(wide_bytes(q.size)) : LEN_W'(word_bytes(q.size));

    // Assertions
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && !txn_ready |=> txn_valid && $stable(txn_addr) && $stable(txn_len))
        else $error("descriptor changed under stall");

    p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> !req_ready)
        else $error("request side open while a descriptor is pending");

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready)
        else $error("still idle after taking a warp");

    p_wide_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && txn_len == LEN_W'(128) && q.size != SZ_W16 && q.size != SZ_RSVD
            |-> txn_addr[6:0] == 7'd0)
        else $error("128-byte transaction not aligned");

    p_len_pow2_r7: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> $countones(txn_len) == 1)
        else $error("illegal transaction length");
endmodule

// File: tb/hw_coalescer_tb.sv
`timescale 1ns/1ps
module hw_coalescer_tb;
    localparam int AW = 32;
    localparam int NW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [NW*AW-1:0] req_addr = '0;
    logic [NW-1:0] req_mask = '0;
    logic [1:0]    req_size = '0;
    logic          txn_valid;
    logic          txn_ready = 1'b1;
    logic [AW-1:0] txn_addr;
    logic [7:0]    txn_len;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] a [NW];
    logic [31:0] m;
    logic [1:0]  sz;
    logic [31:0] ex_addr [$];
    int          ex_len  [$];
    logic [31:0] got_addr[$];
    int          got_len [$];

    always #4 clk = ~clk;

    hw_coalescer u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_mask(req_mask), .req_size(req_size),
        .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_addr(txn_addr), .txn_len(txn_len)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic fill(input logic [31:0] base, input int stride);
        for (int k = 0; k < NW; k++) a[k] = base + 32'(k * stride);
    endtask

    // Expected transactions, built from the merge rule and the issue order.
    task automatic build_expected();
        ex_addr.delete(); ex_len.delete();
        for (int h = 0; h < 2; h++) begin
            int w; int t; int lead; bit ok; logic [31:0] b;
            w = 4 << sz; t = (sz == 0) ? 64 : 128;
            lead = -1;
            for (int k = 0; k < 16; k++) if (m[h*16+k] && lead < 0) lead = k;
            if (lead < 0) continue;
            b  = a[h*16+lead] - 32'(lead * w);
            ok = (sz != 3) && (b % t == 0);
            for (int k = 0; k < 16; k++)
                if (m[h*16+k] && a[h*16+k] != b + 32'(k * w)) ok = 0;
            if (ok) begin
                ex_addr.push_back(b); ex_len.push_back(t);
                if (sz == 2) begin ex_addr.push_back(b + 128); ex_len.push_back(128); end
            end else begin
                for (int k = 0; k < 16; k++)
                    if (m[h*16+k]) begin ex_addr.push_back(a[h*16+k]); ex_len.push_back(w); end
            end
        end
    endtask

    task automatic run_warp(input string rq, input bit stall, output int cycles);
        bit held; logic [31:0] pa; int pl;
        build_expected();
        got_addr.delete(); got_len.delete();
        @(negedge clk);
        req_valid = 1'b1; req_mask = m; req_size = sz;
        for (int k = 0; k < NW; k++) req_addr[k*AW +: AW] = a[k];
        chk(req_ready === 1'b1, "R2", "idle before request", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        cycles = 0; held = 0; pa = '0; pl = 0;
        while (req_ready !== 1'b1 && cycles < 400) begin
            txn_ready = stall ? ((cycles % 3) != 2) : 1'b1;
            #1;
            if (cycles == 0)
                chk(txn_valid === (m[15:0] != 0), "R2", "first-cycle valid", txn_valid, m[15:0] != 0);
            if (held) begin
                chk(txn_valid === 1'b1 && txn_addr == pa && int'(txn_len) == pl,
                    "R11", "held descriptor", txn_addr, pa);
            end
            if (txn_valid) chk(req_ready === 1'b0, "R2", "busy while pending", req_ready, 0);
            if (txn_valid && txn_ready) begin
                got_addr.push_back(txn_addr); got_len.push_back(int'(txn_len));
            end
            held = txn_valid && !txn_ready; pa = txn_addr; pl = int'(txn_len);
            @(negedge clk);
            cycles++;
        end
        txn_ready = 1'b1;
        chk(got_addr.size() == ex_addr.size(), rq, "transaction count", got_addr.size(), ex_addr.size());
        for (int i = 0; i < ex_addr.size() && i < got_addr.size(); i++) begin
            chk(got_addr[i] == ex_addr[i], rq, $sformatf("addr #%0d", i), got_addr[i], ex_addr[i]);
            chk(got_len[i] == ex_len[i], rq, $sformatf("len #%0d", i), got_len[i], ex_len[i]);
        end
    endtask

    task automatic t_reset();
        chk(txn_valid === 1'b0, "R1", "txn_valid after reset", txn_valid, 0);
        chk(req_ready === 1'b1, "R1", "req_ready after reset", req_ready, 1);
    endtask

    task automatic t_merge_w4();
        int c;
        fill(32'h1000, 4); m = '1; sz = 2'd0;
        run_warp("R3", 0, c);
        chk(got_addr.size() == 2 && got_addr[1] == 32'h1040, "R3", "upper half base", got_addr.size(), 2);
    endtask

    task automatic t_merge_w8();
        int c;
        fill(32'h2080, 8); m = '1; sz = 2'd1;
        run_warp("R4", 0, c);
    endtask

    task automatic t_merge_w16();
        int c;
        fill(32'h3000, 16); m = 32'h0000_FFFF; sz = 2'd2;
        run_warp("R5", 0, c);
        chk(got_addr.size() == 2 && got_addr[1] == 32'h3080, "R5", "second half of pair", got_addr.size(), 2);
    endtask

    task automatic t_sparse_mask();
        int c;
        fill(32'h4000, 4); m = 32'hA5A5_0F01; sz = 2'd0;
        a[7] = 32'hDEAD_0000; // inactive thread, arbitrary address
        run_warp("R6", 0, c);
        chk(got_addr.size() == 2, "R6", "inactive lanes still merge", got_addr.size(), 2);
    endtask

    task automatic t_misaligned();
        int c;
        fill(32'h5004, 4); m = 32'h0000_000F; sz = 2'd0;
        run_warp("R7", 0, c);
        chk(got_addr.size() == 4 && got_len[0] == 4, "R6", "misaligned base falls back", got_addr.size(), 4);
    endtask

    task automatic t_swapped();
        int c; logic [31:0] tmp;
        fill(32'h6000, 8); m = 32'h0000_FFFF; sz = 2'd1;
        tmp = a[0]; a[0] = a[1]; a[1] = tmp;
        run_warp("R7", 0, c);
        chk(got_addr.size() == 16 && got_addr[0] == 32'h6008, "R7", "ascending thread order", got_addr[0], 32'h6008);
    endtask

    task automatic t_reserved();
        int c;
        fill(32'h7000, 32); m = 32'h0000_0003; sz = 2'd3;
        run_warp("R8", 0, c);
        chk(got_addr.size() == 2 && got_len[0] == 32, "R8", "reserved code per-thread", got_len.size(), 2);
    endtask

    task automatic t_order();
        int c;
        fill(32'h8000, 4); m = 32'hFFFF_0006; sz = 2'd0;
        a[1] = 32'h9000; // breaks lower half
        run_warp("R9", 0, c);
        chk(got_addr.size() == 3 && got_addr[2] == 32'h8040, "R9", "upper half last", got_addr.size(), 3);
    endtask

    task automatic t_empty();
        int c;
        fill(32'h0, 4); m = '0; sz = 2'd0;
        run_warp("R10", 0, c);
        chk(c <= 3, "R10", "idle again after empty warp", c, 3);
        m = 32'h0003_0000; fill(32'hA000, 4);
        run_warp("R10", 0, c);
    endtask

    task automatic t_stall();
        int c;
        fill(32'hB000, 4); m = 32'h00F0_00F3; sz = 2'd0;
        a[0] = 32'hB100;
        run_warp("R11", 1, c);
        fill(32'hC000, 16); m = '1; sz = 2'd2;
        run_warp("R11", 1, c);
    endtask

    initial begin
        #(8 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_merge_w4();
        t_merge_w8();
        t_merge_w16();
        t_sparse_mask();
        t_misaligned();
        t_swapped();
        t_reserved();
        t_order();
        t_empty();
        t_stall();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule